// File: doc/BRIEF.md
# Host Packet Decoder

This block turns a byte stream from a host link into bus transactions. Each packet starts with a header byte. The two upper bits of the header give the packet type. The six lower bits give either the number of payload bytes that follow or, for command packets, an operation code. Packets therefore have no fixed length. A packet is anything from a single header byte up to a header plus 63 payload bytes.

Bytes enter through a valid/ready port that is cut by a two-entry skid stage. Write, read and timed-write packets are split into one request per address group. Each request is held on a valid/ready request port until the bus side takes it. A read request is followed by a wait for a completion pulse before the decoder consumes further payload. Command headers become one-cycle strobes, one strobe line per defined code. Undefined codes and badly sized packets are reported on one-cycle error lines.

Top module: `hostpkt_decoder`

## Requirements
- R1: Header bits [7:6] select the packet type: 0 = write, 1 = read, 2 = timed write, 3 = command. The request port reports the same value on `req_kind` (0, 1 or 2).
- R2: For a write header, bits [5:0] give the payload length. The payload is read as (address, data) pairs, and each pair produces exactly one request with kind 0, in arrival order.
- R3: For a read header, each payload byte is one address and produces one request with kind 1. After such a request is accepted, no further request is presented until `rd_done` has been seen high.
- R4: For a timed-write header, the payload is read in groups of four bytes: address, data, delay high byte, delay low byte. Each group produces one request with kind 2, and `req_delay` equals {high, low}.
- R5: For a command header, the code is bits [4:0], and bit 5 is ignored. Codes 10 to 20 raise bit (code − 10) of `cmd_pulse` for exactly one cycle. Bit 0 is pause, then in order: unpause, mute, unmute, chip reset, chip disable, chip enable, bus clear, config, controller reset and bootloader (bit 10). At most one bit is ever high.
- R6: A command header with a code outside 10 to 20 raises `cmd_err` for one cycle. It raises no `cmd_pulse` bit and produces no request.
- R7: If the payload length is not a multiple of the group size (2 for write, 4 for timed write), the decoder raises `len_err` for one cycle and discards that many following bytes without issuing requests. A length of zero issues nothing. In both cases the next byte after the packet is treated as a header.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_kind`, `req_addr`, `req_data` and `req_delay` stay unchanged. `req_data` has meaning only for kinds 0 and 2. `req_delay` has meaning only for kind 2.
- R9: A synchronous active-low reset drops any partial packet and returns the decoder to waiting for a header. While reset is active, `req_valid`, `cmd_pulse`, `cmd_err` and `len_err` are 0 and `in_ready` is 1.
- R10: A byte is taken when `in_valid` and `in_ready` are both high. No byte is lost or duplicated, whatever pattern of gaps appears in `in_valid` or stalls appears in `req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Decoder can take a byte |
| req_valid | output | 1 | Bus request presented |
| req_ready | input | 1 | Bus side accepts the request |
| req_kind | output | 2 | 0 write, 1 read, 2 timed write |
| req_addr | output | 8 | Request address |
| req_data | output | 8 | Write data |
| req_delay | output | 16 | Delay word for timed writes |
| rd_done | input | 1 | Read data has come back |
| cmd_pulse | output | 11 | One-cycle command strobes, bit i = code 10+i |
| cmd_err | output | 1 | Undefined command code seen |
| len_err | output | 1 | Payload length not a whole number of groups |

## Verification
The bench goes after four kinds of mistake:
- Mis-sized packets. A design that only flagged the error, without skipping the payload, would decode those bytes as headers and emit stray commands.
- The code mask. Header 0xEA must act as pause. A design that compared six bits would report an error instead.
- Read gating and request holding. The same stream is replayed with request stalls and input gaps. A design that issued the next read early, or moved a stalled request, would show reordered or duplicated log entries.
- Mid-packet reset. A design that kept its payload state through reset would take the next header as an address byte and lose the command.

// File: rtl/hostpkt_pkg.sv
// Shared constants and types for the host packet decoder.
// Assumes headers are one byte: type in [7:6], length or code below it.
package hostpkt_pkg;

    localparam int BYTE_W    = 8;
    localparam int LEN_W     = 6;
    localparam int CODE_W    = 5;
    localparam int DELAY_W   = 16;
    localparam int CMD_FIRST = 10;
    localparam int CMD_COUNT = 11;

    typedef enum logic [1:0] {
        KIND_WRITE  = 2'd0,
        KIND_READ   = 2'd1,
        KIND_TIMED  = 2'd2,
        KIND_CMD    = 2'd3
    } pkt_kind_e;

    typedef enum logic [2:0] {
        ST_HDR,
        ST_PAY,
        ST_ISSUE,
        ST_RDWAIT,
        ST_DRAIN
    } dec_state_e;

    // Payload bytes consumed per request for a given packet type.
    function automatic logic [2:0] group_bytes(input pkt_kind_e k);
        case (k)
            KIND_WRITE: group_bytes = 3'd2;
            KIND_READ:  group_bytes = 3'd1;
            KIND_TIMED: group_bytes = 3'd4;
            default:    group_bytes = 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/hpd_skid.sv
// Two-entry skid stage for a valid/ready byte stream.
// Both in_ready and the outputs come from registers, so no combinational
// path crosses the stage. Assumes the consumer never drops out_valid data.
module hpd_skid #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_ready
);

    logic         spare_v;
    logic [W-1:0] spare_d;

    assign in_ready = !spare_v;

    // Move bytes into the output slot, parking one in the spare slot on a stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            spare_v   <= 1'b0;
            spare_d   <= '0;
        end else if (out_ready || !out_valid) begin
            if (spare_v) begin
                out_valid <= 1'b1;
                out_data  <= spare_d;
                spare_v   <= 1'b0;
            end else begin
                out_valid <= in_valid;
                out_data  <= in_data;
            end
        end else if (in_valid && in_ready) begin
            spare_v <= 1'b1;
            spare_d <= in_data;
        end
    end

    // R10
    skid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

endmodule

// File: rtl/hpd_cmd_decode.sv
// Maps a command code onto one strobe line per defined code.
// Assumes the defined codes form one contiguous range starting at FIRST.
module hpd_cmd_decode #(
    parameter int FIRST  = 10,
    parameter int COUNT  = 11,
    parameter int CODE_W = 5
) (
    input  logic [CODE_W-1:0] code,
    output logic [COUNT-1:0]  onehot,
    output logic              known
);

    // One comparator per defined code.
    for (genvar gi = 0; gi < COUNT; gi++) begin : g_cmp
        assign onehot[gi] = (code == CODE_W'(FIRST + gi));
    end

    assign known = |onehot;

endmodule

// File: rtl/hostpkt_decoder.sv
// Host packet decoder: header-driven parser of a variable-length byte stream.
// Assumes rd_done pulses once per accepted read request. Fields of the
// request port that do not apply to the presented kind are left stale.
module hostpkt_decoder
    import hostpkt_pkg::*;
#(
    parameter int NCMD = CMD_COUNT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [BYTE_W-1:0]   in_data,
    output logic                in_ready,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [1:0]          req_kind,
    output logic [BYTE_W-1:0]   req_addr,
    output logic [BYTE_W-1:0]   req_data,
    output logic [DELAY_W-1:0]  req_delay,
    input  logic                rd_done,
    output logic [NCMD-1:0]     cmd_pulse,
    output logic                cmd_err,
    output logic                len_err
);

    localparam int HALF_D = DELAY_W / 2;

    logic              s_valid;
    logic [BYTE_W-1:0] s_data;
    logic              s_ready;
    logic              take;

    dec_state_e        state;
    pkt_kind_e         kind_q;
    logic [LEN_W-1:0]  remain;
    logic [1:0]        slot;
    logic [BYTE_W-1:0] addr_q;
    logic [BYTE_W-1:0] data_q;
    logic [DELAY_W-1:0] dly_q;

    pkt_kind_e         hdr_kind;
    logic [LEN_W-1:0]  hdr_len;
    logic [LEN_W-1:0]  hdr_mask;
    logic              hdr_misaligned;
    logic [NCMD-1:0]   code_hit;
    logic              code_known;
    logic              slot_last;

    hpd_skid #(.W(BYTE_W)) u_skid (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (s_valid),
        .out_data  (s_data),
        .out_ready (s_ready)
    );

    hpd_cmd_decode #(.FIRST(CMD_FIRST), .COUNT(NCMD), .CODE_W(CODE_W)) u_cmd (
        .code   (s_data[CODE_W-1:0]),
        .onehot (code_hit),
        .known  (code_known)
    );

    // Header fields and the length check for the byte at the skid output.
    always_comb begin
        hdr_kind       = pkt_kind_e'(s_data[BYTE_W-1 -: 2]);
        hdr_len        = s_data[LEN_W-1:0];
        hdr_mask       = LEN_W'(group_bytes(hdr_kind) - 3'd1);
        hdr_misaligned = (hdr_len & hdr_mask) != '0;
        slot_last      = (slot == 2'(group_bytes(kind_q) - 3'd1));
    end

    assign s_ready = (state == ST_HDR) || (state == ST_PAY) || (state == ST_DRAIN);
    assign take    = s_valid && s_ready;

    // Packet state machine: header, payload gathering, issue, read wait, drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_HDR;
            kind_q    <= KIND_WRITE;
            remain    <= '0;
            slot      <= '0;
            addr_q    <= '0;
            data_q    <= '0;
            dly_q     <= '0;
            req_valid <= 1'b0;
            cmd_pulse <= '0;
            cmd_err   <= 1'b0;
            len_err   <= 1'b0;
        end else begin
            cmd_pulse <= '0;
            cmd_err   <= 1'b0;
            len_err   <= 1'b0;
            case (state)
                ST_HDR: if (take) begin
                    if (hdr_kind == KIND_CMD) begin
                        if (code_known) cmd_pulse <= code_hit;
                        else            cmd_err   <= 1'b1;
                    end else if (hdr_len != '0) begin
                        remain <= hdr_len;
                        kind_q <= hdr_kind;
                        slot   <= '0;
                        if (hdr_misaligned) begin
                            len_err <= 1'b1;
                            state   <= ST_DRAIN;
                        end else begin
                            state   <= ST_PAY;
                        end
                    end
                end
                ST_PAY: if (take) begin
                    remain <= remain - 1'b1;
                    case (slot)
                        2'd0:    addr_q <= s_data;
                        2'd1:    data_q <= s_data;
                        2'd2:    dly_q[DELAY_W-1:HALF_D] <= s_data;
                        default: dly_q[HALF_D-1:0] <= s_data;
                    endcase
                    if (slot_last) begin
                        slot      <= '0;
                        req_valid <= 1'b1;
                        state     <= ST_ISSUE;
                    end else begin
                        slot <= slot + 1'b1;
                    end
                end
                ST_ISSUE: if (req_ready) begin
                    req_valid <= 1'b0;
                    if (kind_q == KIND_READ) state <= ST_RDWAIT;
                    else if (remain == '0)   state <= ST_HDR;
                    else                     state <= ST_PAY;
                end
                ST_RDWAIT: if (rd_done) begin
                    state <= (remain == '0) ? ST_HDR : ST_PAY;
                end
                ST_DRAIN: if (take) begin
                    remain <= remain - 1'b1;
                    if (remain == LEN_W'(1)) state <= ST_HDR;
                end
                default: state <= ST_HDR;
            endcase
        end
    end

    assign req_kind  = kind_q;
    assign req_addr  = addr_q;
    assign req_data  = data_q;
    assign req_delay = dly_q;

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid &&
            $stable({req_kind, req_addr, req_data, req_delay}));

    // R3
    read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && (req_kind == 2'd1) |=> !req_valid);

    // R5
    cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_pulse));

    // R6
    cmd_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> (cmd_pulse == '0) && !req_valid);

    // R7
    len_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> !req_valid && (cmd_pulse == '0));

    // R1
    req_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_kind != 2'd3);

endmodule

// File: tb/hostpkt_decoder_test.sv
// Bench: one stream table replayed twice (free-flowing, then stalled),
// then directed reset tests.
module hostpkt_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        req_valid;
    logic        req_ready = 1'b1;
    logic [1:0]  req_kind;
    logic [7:0]  req_addr;
    logic [7:0]  req_data;
    logic [15:0] req_delay;
    logic        rd_done = 1'b0;
    logic [10:0] cmd_pulse;
    logic        cmd_err;
    logic        len_err;

    int checks = 0;
    int failures = 0;
    int log_n = 0;
    logic [35:0] evlog [128];
    bit read_busy = 0;
    bit stall_mode = 0;

    always #4 clk = ~clk;

    hostpkt_decoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data),
        .req_delay(req_delay), .rd_done(rd_done), .cmd_pulse(cmd_pulse),
        .cmd_err(cmd_err), .len_err(len_err)
    );

    // Input stream: mixed packet types, mask case, bad lengths, zero length.
    localparam logic [7:0] STIM [36] = '{
        8'h04, 8'hA1, 8'h11, 8'hA2, 8'h22,
        8'h42, 8'h05, 8'h06,
        8'h84, 8'h30, 8'h77, 8'h01, 8'h02,
        8'hCA, 8'hD4, 8'hC9, 8'hEA,
        8'h03, 8'h01, 8'h02, 8'h03,
        8'h00,
        8'h86, 8'h09, 8'h09, 8'h09, 8'h09, 8'h09, 8'h09,
        8'hD5, 8'hDF, 8'hCB, 8'hD0,
        8'h02, 8'hFF, 8'hEE
    };
    // Expected events {type, addr/code, data, delay}: type 0 W,1 R,2 T,4 cmd,5 cmd_err,6 len_err.
    localparam logic [35:0] EXP [16] = '{
        36'h0A1110000, 36'h0A2220000,
        36'h105000000, 36'h106000000,
        36'h230770102,
        36'h40A000000, 36'h414000000, 36'h500000000, 36'h40A000000,
        36'h600000000, 36'h600000000,
        36'h500000000, 36'h500000000,
        36'h40B000000, 36'h410000000,
        36'h0FFEE0000
    };
    localparam string EXP_REQ [16] = '{
        "R2", "R2", "R3", "R3", "R4", "R5", "R5", "R6", "R5",
        "R7", "R7", "R6", "R6", "R5", "R5", "R1"
    };

    // Monitor: log every transfer and strobe, and check read gating (R3).
    always @(negedge clk) begin
        if (rst_n) begin
            if (req_valid && read_busy) begin
                checks++; failures++;
                $display("FAIL R3 request presented before rd_done: got kind=%0d expected none", req_kind);
            end
            if (rd_done) read_busy = 0;
            if (req_valid && req_ready) begin
                evlog[log_n] = {2'b00, req_kind, req_addr,
                                (req_kind == 2'd1) ? 8'h00 : req_data,
                                (req_kind == 2'd2) ? req_delay : 16'h0000};
                log_n++;
                if (req_kind == 2'd1) read_busy = 1;
            end
            if (cmd_pulse != '0) begin
                for (int i = 0; i < 11; i++)
                    if (cmd_pulse[i]) evlog[log_n] = {4'h4, 8'(10 + i), 24'h0};
                log_n++;
            end
            if (cmd_err) begin evlog[log_n] = {4'h5, 32'h0}; log_n++; end
            if (len_err) begin evlog[log_n] = {4'h6, 32'h0}; log_n++; end
        end
    end

    // Responder: drives req_ready and answers each read two cycles later.
    initial begin
        int wcnt = 0;
        bit fired = 0;
        int cyc = 0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            rd_done = 1'b0;
            req_ready = !stall_mode || (cyc % 3 != 0);
            if (read_busy && !fired) begin
                wcnt++;
                if (wcnt == 2) begin rd_done = 1'b1; fired = 1; wcnt = 0; end
            end else if (!read_busy) begin
                fired = 0;
            end
        end
    end

    task automatic check(input string req, input logic [35:0] got, input logic [35:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        bit ok = 0;
        in_valid = 1'b1;
        in_data  = b;
        while (!ok) begin
            @(negedge clk); ok = in_ready;
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic run_table(input bit gaps, input string tag);
        int base = log_n;
        for (int i = 0; i < 36; i++) begin
            send(STIM[i]);
            if (gaps && (i % 3 == 0)) idle(1);
        end
        idle(60);
        check({tag, " R10 event count"}, 36'(log_n - base), 36'd16);
        for (int i = 0; i < 16; i++)
            check({tag, " ", EXP_REQ[i]}, evlog[base + i], EXP[i]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R10 watchdog expired: got hang expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(3);
        // R9 reset state
        @(negedge clk);
        check("R9 req_valid in reset", 36'(req_valid), 36'd0);
        check("R9 strobes in reset", 36'({cmd_pulse, cmd_err, len_err}), 36'd0);
        check("R9 in_ready in reset", 36'(in_ready), 36'd1);
        @(posedge clk); #1;
        rst_n = 1'b1;
        idle(2);

        // R1 R2 R3 R4 R5 R6 R7: free-flowing pass
        run_table(1'b0, "flow");
        // R8 R10: stalled requests and input gaps, same expected log
        stall_mode = 1;
        run_table(1'b1, "stall");
        stall_mode = 0;

        // R9 reset in the middle of a write packet
        begin
            int base;
            base = log_n;
            send(8'h04);
            send(8'hA1);
            rst_n = 1'b0;
            idle(2);
            @(negedge clk);
            check("R9 req_valid during mid-packet reset", 36'(req_valid), 36'd0);
            @(posedge clk); #1;
            rst_n = 1'b1;
            idle(1);
            send(8'hCB);
            idle(20);
            check("R9 events after reset", 36'(log_n - base), 36'd1);
            check("R9 header after reset", evlog[base], 36'h40B000000);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule